// File: doc/BRIEF.md
# Interrupt-Driven Serial Port on a Byte I/O Bus

This block is an asynchronous serial transmitter and receiver that a small processor drives through four consecutive byte ports on its I/O bus. Each frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. Every bit lasts a programmable number of system clocks, set by a 16-bit divisor that is written as two bytes.

Software loads a byte into the transmit shifter with a write to the data port. It collects the last received byte with a read of the same port. Two live ready bits report whether the transmitter is free and whether an unread byte is waiting. Two separate sticky event flags record that a byte arrived and that the transmitter finished a frame. Any flag that is set raises the single interrupt output. The service routine reads the status port and clears each flag it has handled by writing a one to that flag's bit.

Wiring the serial output back to the serial input gives a loopback path for self-test.

Top module: `sio_irq_uart`

## Requirements
- R1: After reset the serial output is high, the interrupt output is low, the status port reads 0x01 and the divisor reads back as 16 (low byte 0x10, high byte 0x00).
- R2: The ports sit at offsets from the base address 0x80: data at 0x80, status at 0x81, divisor low byte at 0x82, divisor high byte at 0x83. The divisor ports read back what was written. Reads of any other address return 0x00.
- R3: A write to the data port while the transmitter is free sends a frame: start bit 0, the eight data bits LSB first, then stop bit 1. Each bit lasts exactly divisor clocks. Status bit 0 (transmit ready) is 0 for the whole frame.
- R4: A write to the data port while a frame is being sent is ignored. The frame in progress is not changed and no second frame follows.
- R5: Status bit 4 (transmit event flag) sets in the clock that ends the stop bit. It stays set until software clears it.
- R6: The receiver finds the start bit, samples each bit at mid-bit, and when the stop bit is high it makes the byte readable at the data port and sets status bit 1 (receive ready) and status bit 5 (receive event flag).
- R7: A read of the data port clears receive ready and leaves the receive event flag unchanged.
- R8: A status write with bit 5 at 1 clears the receive flag, and with bit 4 at 1 clears the transmit flag. A flag whose bit is written as 0 keeps its value. The ready bits ignore status writes.
- R9: If a flag's set event and its clear write fall in the same clock, the flag ends up set.
- R10: The interrupt output is high exactly while at least one event flag is set.
- R11: A frame whose stop bit is sampled low is discarded. It sets neither receive ready nor the receive flag, and the data port keeps the previous byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ioAddr | input | 8 | I/O port address |
| ioWr | input | 1 | Write strobe, one clock per access |
| ioRd | input | 1 | Read strobe, one clock per access |
| ioWrData | input | 8 | Write data |
| ioRdData | output | 8 | Read data, combinational from the address while ioRd is high, else 0 |
| rxLine | input | 1 | Serial input, idles high |
| txLine | output | 1 | Serial output, idles high |
| irqOut | output | 1 | Interrupt request, high while any event flag is set |

## Verification
The transmitter's end-of-frame event can land in the same clock as software's write-one-to-clear of the transmit flag. This is the overlap that decides whether an event is lost. The bench counts the frame length exactly: ten bit periods of divisor clocks after the edge that takes the data write. It places a status write of 0x10 on that very edge and expects bit 4 to read back as set. It then repeats the write one clock later and expects the flag to read back as clear. This shows that the clear works and that only the coincident case is rescued.

// File: rtl/sio_pkg.sv
package sio_pkg;

  // Control-to-datapath strobes, valid for one clock.
  typedef struct packed {
    logic txLoad;    // data port write
    logic divLoWr;   // divisor low byte write
    logic divHiWr;   // divisor high byte write
  } sioStrobe_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rxState_e;

  // Port offsets within the four-address window.
  localparam logic [1:0] OFS_DATA = 2'd0;
  localparam logic [1:0] OFS_STAT = 2'd1;
  localparam logic [1:0] OFS_DIVL = 2'd2;
  localparam logic [1:0] OFS_DIVH = 2'd3;

  // Status bit positions.
  localparam int unsigned ST_TX_RDY = 0;
  localparam int unsigned ST_RX_RDY = 1;
  localparam int unsigned ST_TX_IRQ = 4;
  localparam int unsigned ST_RX_IRQ = 5;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned DIV_W  = 16;

endpackage

// File: rtl/sio_datapath.sv
module sio_datapath
  import sio_pkg::*;
#(
  parameter logic [DIV_W-1:0] DIV_RESET = 16'd16
) (
  input  logic              clk,
  input  logic              rstN,
  input  sioStrobe_t        strobe,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rxLine,
  output logic              txLine,
  output logic              txBusy,
  output logic              txLastTick,
  output logic              rxGood,
  output logic [BYTE_W-1:0] rxData,
  output logic [DIV_W-1:0]  divisor
);

  localparam int unsigned FRAME_BITS = BYTE_W + 2;
  localparam int unsigned TXB_W      = $clog2(FRAME_BITS);
  localparam int unsigned RXB_W      = $clog2(BYTE_W);
  localparam logic [TXB_W-1:0] TX_LAST = TXB_W'(FRAME_BITS - 1);
  localparam logic [RXB_W-1:0] RX_LAST = RXB_W'(BYTE_W - 1);

  // ---------------- divisor ----------------
  logic [DIV_W-1:0] effDiv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divisor <= DIV_RESET;
    end else begin
      if (strobe.divLoWr) divisor[BYTE_W-1:0]     <= wrData;
      if (strobe.divHiWr) divisor[DIV_W-1:BYTE_W] <= wrData;
    end
  end

  // A bit period shorter than two clocks cannot hold a mid-bit sample.
  assign effDiv = (divisor < DIV_W'(2)) ? DIV_W'(2) : divisor;

  // ---------------- transmitter ----------------
  logic [FRAME_BITS-1:0] txShift;
  logic [DIV_W-1:0]      txCnt;
  logic [TXB_W-1:0]      txBit;
  logic                  txTick;

  assign txTick     = txBusy && (txCnt == '0);
  assign txLastTick = txTick && (txBit == TX_LAST);
  assign txLine     = txShift[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
      txCnt   <= '0;
      txBit   <= '0;
      txBusy  <= 1'b0;
    end else if (strobe.txLoad && !txBusy) begin
      txShift <= {1'b1, wrData, 1'b0};
      txCnt   <= effDiv - DIV_W'(1);
      txBit   <= '0;
      txBusy  <= 1'b1;
    end else if (txBusy) begin
      if (!txTick) begin
        txCnt <= txCnt - DIV_W'(1);
      end else begin
        txShift <= {1'b1, txShift[FRAME_BITS-1:1]};
        txCnt   <= effDiv - DIV_W'(1);
        if (txLastTick) txBusy <= 1'b0;
        else            txBit  <= txBit + TXB_W'(1);
      end
    end
  end

  // ---------------- receiver ----------------
  logic             rxMeta, rxSync;
  rxState_e         rxState;
  logic [DIV_W-1:0] rxCnt;
  logic [RXB_W-1:0] rxBit;
  logic [BYTE_W-1:0] rxShift;
  logic             rxTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxLine;
      rxSync <= rxMeta;
    end
  end

  assign rxTick = (rxCnt == '0);
  assign rxGood = (rxState == RX_STOP) && rxTick && rxSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxCnt   <= '0;
      rxBit   <= '0;
      rxShift <= '0;
      rxData  <= '0;
    end else begin
      unique case (rxState)
        RX_IDLE: begin
          if (!rxSync) begin
            rxState <= RX_START;
            rxCnt   <= (effDiv >> 1) - DIV_W'(1);
          end
        end
        RX_START: begin
          if (!rxTick) begin
            rxCnt <= rxCnt - DIV_W'(1);
          end else if (rxSync) begin
            rxState <= RX_IDLE;           // glitch, not a start bit
          end else begin
            rxState <= RX_DATA;
            rxCnt   <= effDiv - DIV_W'(1);
            rxBit   <= '0;
          end
        end
        RX_DATA: begin
          if (!rxTick) begin
            rxCnt <= rxCnt - DIV_W'(1);
          end else begin
            rxShift <= {rxSync, rxShift[BYTE_W-1:1]};
            rxCnt   <= effDiv - DIV_W'(1);
            if (rxBit == RX_LAST) rxState <= RX_STOP;
            else                  rxBit   <= rxBit + RXB_W'(1);
          end
        end
        RX_STOP: begin
          if (!rxTick) begin
            rxCnt <= rxCnt - DIV_W'(1);
          end else begin
            rxState <= RX_IDLE;
            if (rxSync) rxData <= rxShift;  // framing error drops the byte
          end
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sio_control.sv
module sio_control
  import sio_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [1:0]        clrBits,   // {rx flag clear, tx flag clear}
  input  logic              txBusy,
  input  logic              txLastTick,
  input  logic              rxGood,
  input  logic [BYTE_W-1:0] rxData,
  input  logic [DIV_W-1:0]  divisor,
  output sioStrobe_t        strobe,
  output logic [BYTE_W-1:0] ioRdData,
  output logic              irqOut,
  output logic              txFlag,
  output logic              rxFlag,
  output logic              rxReady
);

  logic       hit;
  logic [1:0] ofs;
  logic       statWr, dataRd;
  logic [BYTE_W-1:0] status;

  assign hit    = (ioAddr[7:2] == BASE_ADDR[7:2]);
  assign ofs    = ioAddr[1:0];
  assign statWr = ioWr && hit && (ofs == OFS_STAT);
  assign dataRd = ioRd && hit && (ofs == OFS_DATA);

  always_comb begin
    strobe         = '0;
    strobe.txLoad  = ioWr && hit && (ofs == OFS_DATA);
    strobe.divLoWr = ioWr && hit && (ofs == OFS_DIVL);
    strobe.divHiWr = ioWr && hit && (ofs == OFS_DIVH);
  end

  // Event flags: a set in the same clock as a clear wins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txFlag  <= 1'b0;
      rxFlag  <= 1'b0;
      rxReady <= 1'b0;
    end else begin
      txFlag  <= (txFlag  & ~(statWr & clrBits[0])) | txLastTick;
      rxFlag  <= (rxFlag  & ~(statWr & clrBits[1])) | rxGood;
      rxReady <= (rxReady & ~dataRd) | rxGood;
    end
  end

  assign irqOut = txFlag | rxFlag;

  always_comb begin
    status            = '0;
    status[ST_TX_RDY] = !txBusy;
    status[ST_RX_RDY] = rxReady;
    status[ST_TX_IRQ] = txFlag;
    status[ST_RX_IRQ] = rxFlag;
  end

  always_comb begin
    ioRdData = '0;
    if (ioRd && hit) begin
      unique case (ofs)
        OFS_DATA: ioRdData = rxData;
        OFS_STAT: ioRdData = status;
        OFS_DIVL: ioRdData = divisor[BYTE_W-1:0];
        OFS_DIVH: ioRdData = divisor[DIV_W-1:BYTE_W];
        default:  ioRdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/sio_irq_uart.sv
module sio_irq_uart
  import sio_pkg::*;
#(
  parameter logic [7:0]       BASE_ADDR = 8'h80,
  parameter logic [DIV_W-1:0] DIV_RESET = 16'd16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] ioAddr,
  input  logic       ioWr,
  input  logic       ioRd,
  input  logic [7:0] ioWrData,
  output logic [7:0] ioRdData,
  input  logic       rxLine,
  output logic       txLine,
  output logic       irqOut
);

  sioStrobe_t        strobe;
  logic              txBusy;
  logic              txLastTick;
  logic              rxGood;
  logic [BYTE_W-1:0] rxData;
  logic [DIV_W-1:0]  divisor;
  logic              txFlag;
  logic              rxFlag;
  logic              rxReady;

  sio_control #(.BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ioAddr     (ioAddr),
    .ioWr       (ioWr),
    .ioRd       (ioRd),
    .clrBits    ({ioWrData[ST_RX_IRQ], ioWrData[ST_TX_IRQ]}),
    .txBusy     (txBusy),
    .txLastTick (txLastTick),
    .rxGood     (rxGood),
    .rxData     (rxData),
    .divisor    (divisor),
    .strobe     (strobe),
    .ioRdData   (ioRdData),
    .irqOut     (irqOut),
    .txFlag     (txFlag),
    .rxFlag     (rxFlag),
    .rxReady    (rxReady)
  );

  sio_datapath #(.DIV_RESET(DIV_RESET)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (ioWrData),
    .rxLine     (rxLine),
    .txLine     (txLine),
    .txBusy     (txBusy),
    .txLastTick (txLastTick),
    .rxGood     (rxGood),
    .rxData     (rxData),
    .divisor    (divisor)
  );

endmodule

// File: rtl/sio_irq_uart_chk.sv
module sio_irq_uart_chk #(
  parameter logic [7:0] BASE_ADDR = 8'h80
) (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  ioAddr,
  input logic        ioWr,
  input logic        ioRd,
  input logic [7:0]  ioWrData,
  input logic        txLine,
  input logic        irqOut,
  input logic        txBusy,
  input logic        txLastTick,
  input logic        rxGood,
  input logic        txFlag,
  input logic        rxFlag,
  input logic        rxReady,
  input logic [15:0] divisor
);

  // R3: the line rests high whenever no frame is in flight.
  p_tx_idle_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txLine);

  // R9: the end of a frame sets the transmit flag, whatever is written.
  p_txflag_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    txLastTick |=> txFlag);

  // R6: an accepted frame raises receive ready and the receive flag.
  p_rx_accept_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxGood |=> (rxReady && rxFlag));

  // R7: a data read with no new byte arriving leaves receive ready low.
  p_rd_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && ioAddr == BASE_ADDR && !rxGood) |=> !rxReady);

  // R10: any flag-setting event raises the interrupt next clock.
  p_irq_raise_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rxGood || txLastTick) |=> irqOut);

  // R10: interrupt low implies both flags low.
  p_irq_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut |-> !(txFlag || rxFlag));

  // R2: a low divisor byte write shows in the divisor next clock.
  p_div_lo_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAddr == (BASE_ADDR | 8'h02)) |=> divisor[7:0] == $past(ioWrData));

endmodule

bind sio_irq_uart sio_irq_uart_chk #(.BASE_ADDR(BASE_ADDR)) u_chk (.*);

// File: tb/sio_irq_uart_tb.sv
`timescale 1ns/100ps
module sio_irq_uart_tb;

  localparam int DIV = 8;
  localparam logic [7:0] A_DATA = 8'h80, A_STAT = 8'h81, A_DIVL = 8'h82, A_DIVH = 8'h83;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] ioAddr = '0, ioWrData = '0;
  logic ioWr = 1'b0, ioRd = 1'b0;
  logic [7:0] ioRdData;
  logic txLine, irqOut, rxLine;
  logic loopOn = 1'b1, rxDrv = 1'b1;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  assign rxLine = loopOn ? txLine : rxDrv;

  sio_irq_uart u_dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .rxLine(rxLine),
    .txLine(txLine), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic wrBus(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  // Side-effect-free read, completed between edges.
  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    ioAddr = a; ioRd = 1'b1;
    #0.5 d = ioRdData;
    ioRd = 1'b0;
  endtask

  task automatic rdData(output logic [7:0] d);
    @(negedge clk);
    ioAddr = A_DATA; ioRd = 1'b1;
    #0.5 d = ioRdData;
    @(negedge clk);
    ioRd = 1'b0;
  endtask

  task automatic waitRx();
    logic [7:0] s;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      peek(A_STAT, s);
      if (s[1]) return;
    end
  endtask

  task automatic sendRaw(input logic [7:0] b, input logic stopBit);
    logic [9:0] fr;
    fr = {stopBit, b, 1'b0};
    loopOn = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      rxDrv = fr[k];
      repeat (DIV - 1) @(negedge clk);
    end
    @(negedge clk);
    rxDrv = 1'b1;
    repeat (3 * DIV) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    @(negedge clk);
    chk("R1 txLine", {7'd0, txLine}, 8'h01);
    chk("R1 irqOut", {7'd0, irqOut}, 8'h00);
    peek(A_STAT, d); chk("R1 status", d, 8'h01);
    peek(A_DIVL, d); chk("R1 divisor low", d, 8'h10);
    peek(A_DIVH, d); chk("R1 divisor high", d, 8'h00);
  endtask

  task automatic t_divisor();
    logic [7:0] d;
    wrBus(A_DIVH, 8'h5A);
    peek(A_DIVH, d); chk("R2 divisor high readback", d, 8'h5A);
    wrBus(A_DIVL, 8'(DIV));
    wrBus(A_DIVH, 8'h00);
    peek(A_DIVL, d); chk("R2 divisor low readback", d, 8'(DIV));
    peek(8'h84, d);  chk("R2 unmapped read", d, 8'h00);
  endtask

  task automatic t_txFrame();
    logic [7:0] d, s;
    logic [9:0] fr;
    logic [7:0] lineBits, expBits;
    fr = {1'b1, 8'hA6, 1'b0};
    loopOn = 1'b1;
    wrBus(A_DATA, 8'hA6);
    repeat (DIV / 2) @(negedge clk);
    peek(A_STAT, s); chk("R3 tx ready low in frame", s & 8'h01, 8'h00);
    for (int k = 0; k < 10; k++) begin
      chk($sformatf("R3 frame bit %0d", k), {7'd0, txLine}, {7'd0, fr[k]});
      if (k < 9) repeat (DIV) @(negedge clk);
    end
    lineBits = 0; expBits = 0;
    repeat (DIV / 2 + 1) @(negedge clk);
    peek(A_STAT, s); chk("R5 R6 flags after frame", s, 8'h33);
    chk("R10 irq with flags", {7'd0, irqOut}, 8'h01);
    rdData(d); chk("R6 loopback byte", d, 8'hA6);
    peek(A_STAT, s); chk("R7 read clears ready only", s, 8'h31);
    wrBus(A_STAT, 8'h20);
    peek(A_STAT, s); chk("R8 rx flag clear", s, 8'h11);
    chk("R10 irq on tx flag alone", {7'd0, irqOut}, 8'h01);
    wrBus(A_STAT, 8'h10);
    peek(A_STAT, s); chk("R8 tx flag clear", s, 8'h01);
    chk("R10 irq low", {7'd0, irqOut}, 8'h00);
  endtask

  task automatic t_busyIgnore();
    logic [7:0] d, s;
    loopOn = 1'b1;
    wrBus(A_DATA, 8'h5A);
    wrBus(A_DATA, 8'hFF);
    waitRx();
    rdData(d); chk("R4 first byte kept", d, 8'h5A);
    repeat (12 * DIV) @(negedge clk);
    peek(A_STAT, s); chk("R4 no second frame", s, 8'h31);
    wrBus(A_STAT, 8'hCF);
    peek(A_STAT, s); chk("R8 zero bits keep flags", s, 8'h31);
    wrBus(A_STAT, 8'h30);
    peek(A_STAT, s); chk("R8 both cleared", s, 8'h01);
  endtask

  task automatic t_rawFrames();
    logic [7:0] d, s;
    sendRaw(8'hC3, 1'b1);
    peek(A_STAT, s); chk("R6 external frame status", s, 8'h23);
    rdData(d); chk("R6 external byte", d, 8'hC3);
    wrBus(A_STAT, 8'h20);
    sendRaw(8'h3C, 1'b0);
    peek(A_STAT, s); chk("R11 bad stop no status", s, 8'h01);
    chk("R11 bad stop no irq", {7'd0, irqOut}, 8'h00);
    rdData(d); chk("R11 previous byte kept", d, 8'hC3);
    loopOn = 1'b1;
  endtask

  task automatic t_clash();
    logic [7:0] d, s;
    loopOn = 1'b1;
    wrBus(A_DATA, 8'h11);
    repeat (10 * DIV - 2) @(negedge clk);
    wrBus(A_STAT, 8'h10);          // clear lands on the frame-end edge
    peek(A_STAT, s); chk("R9 set wins over clear", s & 8'h10, 8'h10);
    wrBus(A_STAT, 8'h30);
    rdData(d);
    wrBus(A_DATA, 8'h22);
    repeat (10 * DIV - 1) @(negedge clk);
    wrBus(A_STAT, 8'h10);          // clear one clock after the set
    peek(A_STAT, s); chk("R8 late clear takes effect", s & 8'h10, 8'h00);
    wrBus(A_STAT, 8'h30);
    rdData(d); chk("R6 second loopback byte", d, 8'h22);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_divisor();
    t_txFrame();
    t_busyIgnore();
    t_rawFrames();
    t_clash();
    summary();
    $finish;
  end

endmodule